// File: doc/BRIEF.md
# Interrupt Controller Command and Setup Decoder

This block is the register side of an eight-line interrupt controller. A host writes bytes to one of two ports. Port 0 is the command port and port 1 is the data port. The block sorts each byte into one of three groups: a start-of-setup word, one of the two run-time command groups, or a plain mask load. It holds the mask, in-service, request and lowest-priority state. It also flags any setting it does not support.

Setup is a short sequence of words. The first one goes to the command port and the rest go to the data port. Two run-time commands retire in-service lines. A non-specific end-of-interrupt clears the in-service line that ranks highest at the current rotation. A specific end-of-interrupt clears a named line. Other codes move the lowest-priority pointer.

A narrow side interface is provided so that state can be observed and set. `req_in` sets request bits. `ack_en` with `ack_idx` moves one line from request into service. A combinational readback mux returns the request, in-service or mask register.

Top module: `pic_cmd_decoder`

## Requirements
- R1: After reset the block is out of setup, the error flag is clear and the lowest priority is 7. Mask, in-service, request, vector base, poll, special-mask, rotate and auto-EOI state are all zero, and readback selects the request register.
- R2: A command-port byte with bit 4 set starts setup. It records bit 0 as "fourth word needed", expects word 2 next, and clears mask, in-service and request. It sets lowest priority to 7, clears auto-EOI and rotate-on-auto-EOI, and so drops `irq_pending`.
- R3: In that start word, bit 1 (single mode) or bit 3 (level-triggered) sets the error flag.
- R4: During setup, data-port bytes are taken in order as word 2, word 3 and word 4. Word 2 stores the byte AND 0xF8 as the vector base. Setup ends after word 3 unless a fourth word was asked for.
- R5: Word 4 ends setup. Its bit 1 sets auto-EOI. If its bit 0 is 0, the error flag is set.
- R6: A data-port byte written outside setup loads the mask register.
- R7: A command byte with bits 4:3 = 01 and bit 2 clear is a control command. Bits 1:0 = 10 select the request register for command-port reads, and 11 select the in-service register. Bits 6:5 = 11 set special mask and 10 clear it. Data-port reads return the mask.
- R8: If such a control byte has bit 2 set, only the poll flag is set. Any read clears the poll flag.
- R9: Command byte 0x80 sets rotate-on-auto-EOI and 0x00 clears it.
- R10: Byte 0x20 clears the first set in-service bit found by scanning upward from lowest priority + 1, modulo 8. Byte 0xA0 does the same and then adds one to the lowest priority, wrapping 7 to 0. If no in-service bit is set, neither byte changes anything.
- R11: For bytes 0x60–0x67, the low 3 bits name an in-service bit, and that bit is cleared. Bytes 0xE0–0xE7 clear that bit and set the lowest priority to it. Bytes 0xC0–0xC7 only set the lowest priority.
- R12: Bytes 0x40 and 0x02 have no effect. Any other command byte with bits 4:3 = 00 that is not listed sets the error flag. The error flag stays set until reset.
- R13: `req_in` bits set request bits. `ack_en` sets in-service bit `ack_idx` and clears the matching request bit. `irq_pending` is high outside setup whenever an unmasked request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Read strobe (clears poll flag) |
| port_sel | input | 1 | 0 command port, 1 data port |
| wr_data | input | 8 | Write byte |
| req_in | input | 8 | Request set bits |
| ack_en | input | 1 | Move one line from request to service |
| ack_idx | input | 3 | Line acknowledged |
| rd_data | output | 8 | Readback |
| imr_q | output | 8 | Mask register |
| isr_q | output | 8 | In-service register |
| vec_base | output | 8 | Vector base |
| auto_eoi | output | 1 | Auto-EOI mode |
| rot_aeoi | output | 1 | Rotate-on-auto-EOI |
| read_isr | output | 1 | Readback selects in-service |
| poll_flag | output | 1 | Poll pending |
| spec_mask | output | 1 | Special mask mode |
| lowest_prio | output | 3 | Lowest-priority line |
| in_init | output | 1 | Setup in progress |
| irq_pending | output | 1 | Unmasked request present |
| cfg_err | output | 1 | Sticky unsupported-setting flag |

## Verification
The bench fills the in-service register and then steps through end-of-interrupt codes at several rotation points. If the upward scan started at the wrong place, a different bit would be cleared. If 0xA0 advanced the pointer with nothing in service, the lowest priority would drift off 7. A separate test runs setup without a fourth word. If the sequencer always waited for word 4, the next mask load would be swallowed. Error tests cover both bad start bits, a fourth word with bit 0 at 0, and an unlisted code followed by a valid one. A flag that was not sticky would clear on that valid write.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int W  = 8;
  localparam int IW = $clog2(W);

  typedef struct packed {
    logic icw1;
    logic icw1_bad;
    logic ocw3;
    logic poll;
    logic rr_irr;
    logic rr_isr;
    logic smm_clr;
    logic smm_set;
    logic rot_clr;
    logic rot_set;
    logic ns_eoi;
    logic ns_rot;
    logic sp_eoi;
    logic lp_set;
    logic bad;
    logic [IW-1:0] idx;
  } cmd_t;

  // first set bit scanning upward from lp+1 (mod W); {hit, index}
  function automatic logic [IW:0] top_isr(input logic [W-1:0] vec, input logic [IW-1:0] lp);
    logic [IW:0]   r;
    logic [IW-1:0] p;
    r = '0;
    for (int k = W - 1; k >= 0; k--) begin
      p = lp + IW'(1) + IW'(k);
      if (vec[p]) r = {1'b1, p};
    end
    return r;
  endfunction

  function automatic logic [W-1:0] bit_of(input logic [IW-1:0] i);
    return W'(1) << i;
  endfunction
endpackage

// File: rtl/pic_cmd_dec.sv
module pic_cmd_dec
  import pic_pkg::*;
(
  input  logic         wr,
  input  logic [W-1:0] d,
  output cmd_t         c
);
  always_comb begin
    c     = '0;
    c.idx = d[IW-1:0];
    if (wr) begin
      if (d[4]) begin
        c.icw1     = 1'b1;
        c.icw1_bad = d[1] | d[3];
      end else if (d[3]) begin
        c.ocw3 = 1'b1;
        if (d[2]) c.poll = 1'b1;
        else begin
          c.rr_irr  = (d[1:0] == 2'b10);
          c.rr_isr  = (d[1:0] == 2'b11);
          c.smm_clr = (d[6:5] == 2'b10);
          c.smm_set = (d[6:5] == 2'b11);
        end
      end else begin
        case (d[7:5])
          3'b000: begin
            if (d[2:0] == 3'b000) c.rot_clr = 1'b1;
            else if (d[2:0] != 3'b010) c.bad = 1'b1;
          end
          3'b100: if (d[2:0] == 3'b000) c.rot_set = 1'b1; else c.bad = 1'b1;
          3'b001: if (d[2:0] == 3'b000) c.ns_eoi = 1'b1; else c.bad = 1'b1;
          3'b101: if (d[2:0] == 3'b000) begin c.ns_eoi = 1'b1; c.ns_rot = 1'b1; end
                  else c.bad = 1'b1;
          3'b010: if (d[2:0] != 3'b000) c.bad = 1'b1;
          3'b011: c.sp_eoi = 1'b1;
          3'b111: begin c.sp_eoi = 1'b1; c.lp_set = 1'b1; end
          default: c.lp_set = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         need4_in,
  input  logic         dwr,
  input  logic [W-1:0] d,
  output logic         in_init,
  output logic [W-1:0] vec,
  output logic         aeoi,
  output logic         imr_load,
  output logic         word4_bad
);
  typedef enum logic [1:0] {WANT2, WANT3, WANT4} step_t;
  step_t step;
  logic  need4;

  assign imr_load  = dwr & ~in_init;
  assign word4_bad = dwr & in_init & (step == WANT4) & ~d[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_init <= 1'b0;
      step    <= WANT2;
      need4   <= 1'b0;
      vec     <= '0;
      aeoi    <= 1'b0;
    end else if (start) begin
      in_init <= 1'b1;
      step    <= WANT2;
      need4   <= need4_in;
      aeoi    <= 1'b0;
    end else if (dwr && in_init) begin
      case (step)
        WANT2: begin vec <= d & W'(8'hF8); step <= WANT3; end
        WANT3: if (need4) step <= WANT4; else in_init <= 1'b0;
        default: begin aeoi <= d[1]; in_init <= 1'b0; end
      endcase
    end
  end
endmodule

// File: rtl/pic_prio_scan.sv
module pic_prio_scan
  import pic_pkg::*;
(
  input  logic [W-1:0]  isr,
  input  logic [IW-1:0] lp,
  output logic          hit,
  output logic [IW-1:0] idx
);
  assign {hit, idx} = top_isr(isr, lp);
endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder
  import pic_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          port_sel,
  input  logic [W-1:0]  wr_data,
  input  logic [W-1:0]  req_in,
  input  logic          ack_en,
  input  logic [IW-1:0] ack_idx,
  output logic [W-1:0]  rd_data,
  output logic [W-1:0]  imr_q,
  output logic [W-1:0]  isr_q,
  output logic [W-1:0]  vec_base,
  output logic          auto_eoi,
  output logic          rot_aeoi,
  output logic          read_isr,
  output logic          poll_flag,
  output logic          spec_mask,
  output logic [IW-1:0] lowest_prio,
  output logic          in_init,
  output logic          irq_pending,
  output logic          cfg_err
);
  cmd_t          cmd;
  logic [W-1:0]  irr_q;
  logic          scan_hit;
  logic [IW-1:0] scan_idx;

  // named events for the checker
  logic ev_icw1, ev_imr_load, ev_poll, ev_lp_set, ev_sp_eoi, ev_word4_bad;
  logic [W-1:0] ack_mask, clr_mask;

  pic_cmd_dec u_dec (.wr(wr_en & ~port_sel), .d(wr_data), .c(cmd));

  pic_init_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(cmd.icw1), .need4_in(wr_data[0]),
    .dwr(wr_en & port_sel), .d(wr_data), .in_init(in_init), .vec(vec_base),
    .aeoi(auto_eoi), .imr_load(ev_imr_load), .word4_bad(ev_word4_bad)
  );

  pic_prio_scan u_scan (.isr(isr_q), .lp(lowest_prio), .hit(scan_hit), .idx(scan_idx));

  assign ev_icw1   = cmd.icw1;
  assign ev_poll   = cmd.poll;
  assign ev_lp_set = cmd.lp_set;
  assign ev_sp_eoi = cmd.sp_eoi;
  assign ack_mask  = ack_en ? bit_of(ack_idx) : '0;
  assign clr_mask  = ((cmd.ns_eoi && scan_hit) ? bit_of(scan_idx) : '0)
                   | (cmd.sp_eoi ? bit_of(cmd.idx) : '0);

  assign rd_data     = port_sel ? imr_q : (read_isr ? isr_q : irr_q);
  assign irq_pending = ~in_init & (|(irr_q & ~imr_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imr_q       <= '0;
      isr_q       <= '0;
      irr_q       <= '0;
      lowest_prio <= '1;
      rot_aeoi    <= 1'b0;
      spec_mask   <= 1'b0;
      read_isr    <= 1'b0;
      poll_flag   <= 1'b0;
      cfg_err     <= 1'b0;
    end else begin
      if (rd_en) poll_flag <= 1'b0;
      if (cmd.icw1) begin
        imr_q       <= '0;
        isr_q       <= '0;
        irr_q       <= '0;
        lowest_prio <= '1;
        rot_aeoi    <= 1'b0;
        if (cmd.icw1_bad) cfg_err <= 1'b1;
      end else begin
        irr_q <= (irr_q | req_in) & ~ack_mask;
        isr_q <= (isr_q | ack_mask) & ~clr_mask;
        if (ev_imr_load) imr_q <= wr_data;
        if (cmd.poll)    poll_flag <= 1'b1;
        if (cmd.rr_irr)  read_isr  <= 1'b0;
        if (cmd.rr_isr)  read_isr  <= 1'b1;
        if (cmd.smm_clr) spec_mask <= 1'b0;
        if (cmd.smm_set) spec_mask <= 1'b1;
        if (cmd.rot_clr) rot_aeoi  <= 1'b0;
        if (cmd.rot_set) rot_aeoi  <= 1'b1;
        if (cmd.ns_rot && scan_hit) lowest_prio <= lowest_prio + IW'(1);
        if (cmd.lp_set)  lowest_prio <= cmd.idx;
        if (cmd.bad || ev_word4_bad) cfg_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pic_cmd_checker.sv
module pic_cmd_checker
  import pic_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          ack_en,
  input logic [W-1:0]  wr_data,
  input logic          ev_icw1,
  input logic          ev_imr_load,
  input logic          ev_poll,
  input logic          ev_lp_set,
  input logic          ev_sp_eoi,
  input logic [W-1:0]  isr_q,
  input logic [W-1:0]  imr_q,
  input logic [IW-1:0] lowest_prio,
  input logic          in_init,
  input logic          auto_eoi,
  input logic          poll_flag,
  input logic          cfg_err
);
  p_icw1_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_icw1 |=> (isr_q == '0) && (imr_q == '0) && (lowest_prio == '1) && in_init && !auto_eoi);

  p_bad_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_icw1 && (wr_data[1] || wr_data[3])) |=> cfg_err);

  p_imr_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_imr_load |=> imr_q == $past(wr_data));

  p_poll_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_poll |=> poll_flag);

  p_poll_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && poll_flag && !ev_poll) |=> !poll_flag);

  p_lp_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lp_set |=> lowest_prio == $past(wr_data[IW-1:0]));

  p_spec_eoi_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sp_eoi && !ack_en) |=> (isr_q & (W'(1) << $past(wr_data[IW-1:0]))) == '0);

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
endmodule

bind pic_cmd_decoder pic_cmd_checker i_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .ack_en(ack_en), .wr_data(wr_data),
  .ev_icw1(ev_icw1), .ev_imr_load(ev_imr_load), .ev_poll(ev_poll),
  .ev_lp_set(ev_lp_set), .ev_sp_eoi(ev_sp_eoi), .isr_q(isr_q), .imr_q(imr_q),
  .lowest_prio(lowest_prio), .in_init(in_init), .auto_eoi(auto_eoi),
  .poll_flag(poll_flag), .cfg_err(cfg_err)
);

// File: tb/test_pic_cmd_decoder.sv
`timescale 1ns/1ps
module test_pic_cmd_decoder;
  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, port_sel = 1'b0, ack_en = 1'b0;
  logic [7:0] wr_data = '0, req_in = '0;
  logic [2:0] ack_idx = '0;
  logic [7:0] rd_data, imr_q, isr_q, vec_base;
  logic       auto_eoi, rot_aeoi, read_isr, poll_flag, spec_mask, in_init, irq_pending, cfg_err;
  logic [2:0] lowest_prio;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  pic_cmd_decoder i_pic_cmd_decoder (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic p, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; port_sel = p; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic p, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; port_sel = p; #1 v = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ack(input logic [2:0] i);
    @(negedge clk); ack_en = 1'b1; ack_idx = i;
    @(negedge clk); ack_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // {port, byte, expected lowest_prio, expected imr, expected isr}
  localparam logic [27:0] TBL [14] = '{
    {1'b0, 8'h20, 3'd7, 8'h00, 8'hFE},
    {1'b0, 8'hA0, 3'd0, 8'h00, 8'hFC},
    {1'b0, 8'h20, 3'd0, 8'h00, 8'hF8},
    {1'b0, 8'h65, 3'd0, 8'h00, 8'hD8},
    {1'b0, 8'hC3, 3'd3, 8'h00, 8'hD8},
    {1'b0, 8'h20, 3'd3, 8'h00, 8'hC8},
    {1'b0, 8'hE6, 3'd6, 8'h00, 8'h88},
    {1'b0, 8'h20, 3'd6, 8'h00, 8'h08},
    {1'b0, 8'h40, 3'd6, 8'h00, 8'h08},
    {1'b0, 8'h02, 3'd6, 8'h00, 8'h08},
    {1'b1, 8'h5A, 3'd6, 8'h5A, 8'h08},
    {1'b0, 8'hA0, 3'd7, 8'h5A, 8'h00},
    {1'b0, 8'h20, 3'd7, 8'h5A, 8'h00},
    {1'b0, 8'hA0, 3'd7, 8'h5A, 8'h00}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    do_reset();
    // R1 reset state
    chk("R1 isr", isr_q, 0); chk("R1 imr", imr_q, 0); chk("R1 lp", lowest_prio, 7);
    chk("R1 err", cfg_err, 0); chk("R1 init", in_init, 0); chk("R1 vec", vec_base, 0);
    chk("R1 poll", poll_flag, 0); chk("R1 sel", read_isr, 0);
    rd(1'b0, v); chk("R1 read irr", v, 0);

    // R2/R4/R5 setup with fourth word
    wr(1'b0, 8'h11); chk("R2 in_init", in_init, 1);
    wr(1'b1, 8'h4F); chk("R4 vec", vec_base, 8'h48);
    wr(1'b1, 8'h04); chk("R4 wait word4", in_init, 1);
    wr(1'b1, 8'h01); chk("R5 done", in_init, 0); chk("R5 aeoi", auto_eoi, 0); chk("R5 err", cfg_err, 0);

    // R13 ack and requests
    for (int i = 0; i < 8; i++) ack(3'(i));
    chk("R13 isr", isr_q, 8'hFF);
    @(negedge clk); req_in = 8'h24; @(negedge clk); req_in = 8'h00;
    rd(1'b0, v); chk("R13 irr read", v, 8'h24); chk("R13 pending", irq_pending, 1);

    // R10/R11/R12/R6 table walk
    for (int i = 0; i < 14; i++) begin
      wr(TBL[i][27], TBL[i][26:19]);
      chk("R10 R11 lp", lowest_prio, TBL[i][18:16]);
      chk("R6 R12 imr", imr_q, TBL[i][15:8]);
      chk("R10 R11 R12 isr", isr_q, TBL[i][7:0]);
      chk("R12 no err", cfg_err, 0);
    end

    // R7 readback select and special mask
    ack(3'd4);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R7 read isr", v, 8'h10);
    wr(1'b0, 8'h0A); rd(1'b0, v); chk("R7 read irr", v, 8'h24);
    rd(1'b1, v); chk("R7 read imr", v, 8'h5A);
    wr(1'b0, 8'h68); chk("R7 smm set", spec_mask, 1);
    wr(1'b0, 8'h48); chk("R7 smm clr", spec_mask, 0);

    // R8 poll
    wr(1'b0, 8'h6C); chk("R8 poll set", poll_flag, 1); chk("R8 smm untouched", spec_mask, 0);
    rd(1'b0, v); chk("R8 poll cleared", poll_flag, 0);

    // R9 rotate on auto EOI
    wr(1'b0, 8'h80); chk("R9 set", rot_aeoi, 1);
    wr(1'b0, 8'h00); chk("R9 clr", rot_aeoi, 0);

    // R2 restart mid-operation, R4 no-fourth-word path
    ack(3'd2); wr(1'b1, 8'hFF); wr(1'b0, 8'hC2); wr(1'b0, 8'h80);
    wr(1'b0, 8'h10);
    chk("R2 isr", isr_q, 0); chk("R2 imr", imr_q, 0); chk("R2 lp", lowest_prio, 7);
    chk("R2 rot", rot_aeoi, 0); chk("R2 init", in_init, 1); chk("R2 pending", irq_pending, 0);
    rd(1'b0, v); chk("R2 irr", v, 0);
    wr(1'b1, 8'h20); chk("R4 vec2", vec_base, 8'h20);
    wr(1'b1, 8'h04); chk("R4 ends after word3", in_init, 0);
    wr(1'b1, 8'h33); chk("R6 imr", imr_q, 8'h33);

    // R5 auto EOI
    wr(1'b0, 8'h11); wr(1'b1, 8'h08); wr(1'b1, 8'h04); wr(1'b1, 8'h03);
    chk("R5 aeoi", auto_eoi, 1); chk("R5 ok", cfg_err, 0);

    // R12 unlisted code, sticky
    wr(1'b0, 8'h21); chk("R12 err", cfg_err, 1);
    wr(1'b0, 8'h20); chk("R12 sticky", cfg_err, 1);
    do_reset(); chk("R1 err cleared", cfg_err, 0);
    // R3 bad start words
    wr(1'b0, 8'h18); chk("R3 level", cfg_err, 1);
    do_reset();
    wr(1'b0, 8'h12); chk("R3 single", cfg_err, 1);
    // R5 word4 bit0 clear
    do_reset();
    wr(1'b0, 8'h11); wr(1'b1, 8'h00); wr(1'b1, 8'h04); wr(1'b1, 8'h02);
    chk("R5 bad word4", cfg_err, 1); chk("R5 aeoi2", auto_eoi, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule